// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block maps a 24-bit processor address onto a 23-bit physical address through two lookup tables. The first table is the segment table. A 4-bit address-space tag and the six address bits just above the 32 KB segment boundary select one of its 1024 entries. That entry returns an 8-bit logical segment number and 4 protection bits. The second table is the page table. The low six bits of that logical number, together with the four address bits that pick a 2 KB page inside the segment, select one of its 1024 entries. That entry returns a 12-bit physical page number and 4 mode bits. The 11-bit byte offset passes through unchanged. The top two logical bits are kept in the table but take no part in translation.

Only the lowest 2 MB of the address range is translated. Everything above it is passed through as on-board space. Three windows in the upper range let software reach the tag register and both tables. The address that falls in the segment window selects a segment entry exactly as a translated access would. The address that falls in the page window selects a page entry through the segment table. So an entry is written at the same address from which it is read back. Protection, mode and translated address are handed to a separate fault and routing block.

Top module: `seg_page_xlate`

## Requirements
- R1: `xlate` is 1 exactly when `cpu_addr` < 0x200000 (bits 23:21 all zero).
- R2: The address-space tag is 0 after reset. A write with `cpu_addr[23:21]` = 3'b111 loads `cpu_wdata[15:12]` into the tag, so a write of 0x7000 selects tag 7. A read in that window returns {tag, 12'h000}.
- R3: On a translated access the segment entry is selected by {tag, cpu_addr[20:15]}, and `prot` shows bits 11:8 of that entry.
- R4: The page entry is selected by {segment entry bits 5:0, cpu_addr[14:11]}. Segment entry bits 7:6 have no effect on translation.
- R5: On a translated access `phys_addr` = {page entry bits 11:0, cpu_addr[10:0]} and `mode` = page entry bits 15:12.
- R6: A write with `cpu_addr[23:21]` = 3'b110 stores `cpu_wdata[11:0]` into the segment entry at {tag, cpu_addr[20:15]}. The base is 0xC00000 and the stride is 0x8000.
- R7: A write with `cpu_addr[23:21]` = 3'b101 stores `cpu_wdata[15:0]` into the page entry at {segment entry bits 5:0, cpu_addr[14:11]}. That segment entry is selected as in R6 from the write address. The base is 0xA00000 and the stride is 0x800.
- R8: `rd_data` returns the selected entry in the segment window (zero-extended from 12 bits) and in the page window. It returns 0 for addresses in 0x200000..0x9FFFFF. During a write cycle it still shows the contents from before the write. Writes outside the three windows change nothing.
- R9: When `xlate` is 0, `phys_addr` = `cpu_addr[22:0]` and `mode` = `prot` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | Processor address |
| cpu_wr | input | 1 | Write strobe for the current address |
| cpu_wdata | input | 16 | Write data |
| xlate | output | 1 | Address is in the translated range |
| phys_addr | output | 23 | Physical address |
| mode | output | 4 | Page mode bits |
| prot | output | 4 | Segment protection bits |
| rd_data | output | 16 | Read-back of tag or table entry |

## Verification
A wrong tag value, or a corrupted segment entry, shows up in the same cycle as a changed `prot` and a wrong physical page, or a wrong page read-back, for every address that touches it. The fault can also surface one level later. A bad segment entry sends page writes to the wrong page entry. That only shows at the ports when the victim page is next translated or read back. So the bench translates and reads back every entry it has written, and does so again after switching the tag. An off-by-one cycle in write timing shows on `rd_data` during the write cycle itself.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;
  parameter int VA_W     = 24;
  parameter int OFF_W    = 11;
  parameter int PSEL_W   = 4;
  parameter int SSEL_W   = 6;
  parameter int TAG_W    = 4;
  parameter int LOG_W    = 8;
  parameter int PROT_W   = 4;
  parameter int PPN_W    = 12;
  parameter int MODE_W   = 4;
  parameter int D_W      = 16;
  parameter int WIN_W    = 3;
  parameter logic [WIN_W-1:0] WIN_XLT = 3'b000;
  parameter logic [WIN_W-1:0] WIN_PG  = 3'b101;
  parameter logic [WIN_W-1:0] WIN_SEG = 3'b110;
  parameter logic [WIN_W-1:0] WIN_TAG = 3'b111;

  typedef enum logic [1:0] {
    AREA_NONE = 2'd0,
    AREA_TAG  = 2'd1,
    AREA_SEG  = 2'd2,
    AREA_PG   = 2'd3
  } area_e;
endpackage

// File: rtl/xlt_rst_sync.sv
`timescale 1ns/1ps
module xlt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/xlt_win_dec.sv
`timescale 1ns/1ps
module xlt_win_dec
  import xlt_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  input  logic             wr,
  output logic             in_xlt,
  output area_e            area,
  output logic             we_tag,
  output logic             we_seg,
  output logic             we_pg
);
  always_comb begin
    in_xlt = (win == WIN_XLT);
    unique case (win)
      WIN_TAG: area = AREA_TAG;
      WIN_SEG: area = AREA_SEG;
      WIN_PG:  area = AREA_PG;
      default: area = AREA_NONE;
    endcase
    we_tag = wr && (area == AREA_TAG);
    we_seg = wr && (area == AREA_SEG);
    we_pg  = wr && (area == AREA_PG);
  end
endmodule

// File: rtl/xlt_tag_reg.sv
`timescale 1ns/1ps
module xlt_tag_reg #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [TAG_W-1:0] din,
  output logic [TAG_W-1:0] tag
);
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tag_d;

  always_comb tag_d = ld ? din : tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  assign tag = tag_q;

  // R2
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(tag_q));
  // R2
  tag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (tag_q == $past(din)));
endmodule

// File: rtl/xlt_map_ram.sv
`timescale 1ns/1ps
module xlt_map_ram #(
  parameter int IDX_W = 10,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DAT_W-1:0] wr_dat,
  output logic [DAT_W-1:0] rd_dat
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wr_dat;
  end

  assign rd_dat = mem[idx];

  // R6 and R7: a written entry reads back on the next cycle
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((idx != $past(idx)) || (rd_dat == $past(wr_dat))));
endmodule

// File: rtl/seg_page_xlate.sv
`timescale 1ns/1ps
module seg_page_xlate
  import xlt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [VA_W-1:0]         cpu_addr,
  input  logic                    cpu_wr,
  input  logic [D_W-1:0]          cpu_wdata,
  output logic                    xlate,
  output logic [PPN_W+OFF_W-1:0]  phys_addr,
  output logic [MODE_W-1:0]       mode,
  output logic [PROT_W-1:0]       prot,
  output logic [D_W-1:0]          rd_data
);
  localparam int SIDX_W = TAG_W + SSEL_W;
  localparam int PIDX_W = SSEL_W + PSEL_W;
  localparam int SDAT_W = LOG_W + PROT_W;
  localparam int PDAT_W = PPN_W + MODE_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int SSEL_LO = OFF_W + PSEL_W;

  logic               rst_q_n;
  logic               in_xlt;
  area_e              area;
  logic               we_tag, we_seg, we_pg;
  logic [TAG_W-1:0]   tag;
  logic [SIDX_W-1:0]  seg_idx;
  logic [PIDX_W-1:0]  pg_idx;
  logic [SDAT_W-1:0]  seg_rd;
  logic [PDAT_W-1:0]  pg_rd;

  xlt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  xlt_win_dec u_dec (
    .win(cpu_addr[VA_W-1 -: WIN_W]), .wr(cpu_wr), .in_xlt(in_xlt),
    .area(area), .we_tag(we_tag), .we_seg(we_seg), .we_pg(we_pg)
  );

  xlt_tag_reg #(.TAG_W(TAG_W)) u_tag (
    .clk(clk), .rst_n(rst_q_n), .ld(we_tag),
    .din(cpu_wdata[D_W-1 -: TAG_W]), .tag(tag)
  );

  always_comb seg_idx = {tag, cpu_addr[SSEL_LO +: SSEL_W]};

  xlt_map_ram #(.IDX_W(SIDX_W), .DAT_W(SDAT_W)) u_seg (
    .clk(clk), .rst_n(rst_q_n), .we(we_seg), .idx(seg_idx),
    .wr_dat(cpu_wdata[SDAT_W-1:0]), .rd_dat(seg_rd)
  );

  always_comb pg_idx = {seg_rd[SSEL_W-1:0], cpu_addr[OFF_W +: PSEL_W]};

  xlt_map_ram #(.IDX_W(PIDX_W), .DAT_W(PDAT_W)) u_pg (
    .clk(clk), .rst_n(rst_q_n), .we(we_pg), .idx(pg_idx),
    .wr_dat(cpu_wdata[PDAT_W-1:0]), .rd_dat(pg_rd)
  );

  always_comb begin
    xlate = in_xlt;
    if (in_xlt) begin
      phys_addr = {pg_rd[PPN_W-1:0], cpu_addr[OFF_W-1:0]};
      mode      = pg_rd[PDAT_W-1 -: MODE_W];
      prot      = seg_rd[SDAT_W-1 -: PROT_W];
    end else begin
      phys_addr = cpu_addr[PA_W-1:0];
      mode      = '0;
      prot      = '0;
    end
  end

  always_comb begin
    unique case (area)
      AREA_TAG: rd_data = {tag, {(D_W-TAG_W){1'b0}}};
      AREA_SEG: rd_data = D_W'(seg_rd);
      AREA_PG:  rd_data = D_W'(pg_rd);
      default:  rd_data = '0;
    endcase
  end

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    xlate |-> (phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));
  // R9
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !xlate |-> (mode == '0 && prot == '0 && phys_addr == cpu_addr[PA_W-1:0]));
  // R1
  range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    xlate |-> (cpu_addr < VA_W'(1 << (SSEL_LO + SSEL_W))));
endmodule

// File: tb/seg_page_xlate_tb.sv
`timescale 1ns/1ps
module seg_page_xlate_tb;
  logic        clk;
  logic        rst_n;
  logic [23:0] cpu_addr;
  logic        cpu_wr;
  logic [15:0] cpu_wdata;
  logic        xlate;
  logic [22:0] phys_addr;
  logic [3:0]  mode;
  logic [3:0]  prot;
  logic [15:0] rd_data;

  seg_page_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .xlate(xlate), .phys_addr(phys_addr),
    .mode(mode), .prot(prot), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int ref_tag;
  int ref_seg [1024];
  bit seg_ok [1024];
  int ref_pg [1024];
  bit pg_ok [1024];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at addr 0x%06h",
               req, what, act, exp, cpu_addr);
    end
  endtask

  task automatic step(input int a, input bit w, input int d);
    int sidx, pidx, win, exp_rd;
    bit rd_known, pidx_ok;
    @(negedge clk);
    cpu_addr = a[23:0]; cpu_wr = w; cpu_wdata = d[15:0];
    #2;
    win  = (a >> 21) & 7;
    sidx = ref_tag * 64 + ((a >> 15) & 63);
    pidx_ok = seg_ok[sidx];
    pidx = pidx_ok ? ((ref_seg[sidx] & 63) * 16 + ((a >> 11) & 15)) : 0;
    chk("R1", "xlate", int'(xlate), (win == 0) ? 1 : 0);
    if (win == 0) begin
      if (seg_ok[sidx]) begin
        chk("R3", "prot", int'(prot), (ref_seg[sidx] >> 8) & 15);
        if (pg_ok[pidx]) begin
          // R4 and R5: page chosen by segment bits 5:0 only
          chk("R5", "phys", int'(phys_addr), ((ref_pg[pidx] & 12'hFFF) << 11) | (a & 11'h7FF));
          chk("R5", "mode", int'(mode), (ref_pg[pidx] >> 12) & 15);
        end
      end
    end else begin
      chk("R9", "phys", int'(phys_addr), a & 23'h7FFFFF);
      chk("R9", "mode+prot", int'({mode, prot}), 0);
    end
    rd_known = 1'b1;
    exp_rd = 0;
    case (win)
      7: exp_rd = ref_tag << 12;
      6: begin rd_known = seg_ok[sidx]; exp_rd = ref_seg[sidx]; end
      5: begin rd_known = pidx_ok && pg_ok[pidx]; exp_rd = ref_pg[pidx]; end
      default: exp_rd = 0;
    endcase
    if (rd_known) chk((win == 7) ? "R2" : "R8", "rd_data", int'(rd_data), exp_rd);
    @(posedge clk);
    #1;
    if (w) begin
      case (win)
        7: ref_tag = (d >> 12) & 15;
        6: begin ref_seg[sidx] = d & 12'hFFF; seg_ok[sidx] = 1'b1; end
        5: if (pidx_ok) begin ref_pg[pidx] = d & 16'hFFFF; pg_ok[pidx] = 1'b1; end
        default: ;
      endcase
    end
    cpu_wr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      seg_ok[i] = 1'b0; pg_ok[i] = 1'b0; ref_seg[i] = 0; ref_pg[i] = 0;
    end
    ref_tag = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_wr = 1'b0; cpu_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2: tag is 0 after reset
    step(24'hE00000, 0, 0);

    // R6: identity segment table in tag 0 with varied protection
    for (int i = 0; i < 64; i++) step(24'hC00000 + (i << 15), 1, i | ((i % 16) << 8));
    // R4: bits 7:6 set on entry 5 must not move its pages
    step(24'hC00000 + (5 << 15), 1, 16'h03C5);
    // R7: pages for segments 0..7 and the top page
    for (int n = 0; n < 128; n++) step(24'hA00000 + (n << 11), 1, ((n % 16) << 12) | ((n * 37 + 1) & 12'hFFF));
    step(24'hBFF800, 1, 16'h7ABC);

    // R8: read back segment and page entries
    for (int i = 0; i < 8; i++) step(24'hC00000 + (i << 15), 0, 0);
    for (int n = 0; n < 128; n += 9) step(24'hA00000 + (n << 11), 0, 0);

    // R3 R5: translated accesses
    for (int k = 0; k < 40; k++) step((k * 32'h1357B) % 32'h40000, 0, 0);
    // R1: range boundary
    step(24'h1FFFFF, 0, 0);
    step(24'h200000, 0, 0);
    step(24'h3FFFFF, 0, 0);
    step(24'h812345, 0, 0);

    // R8: writes outside the windows change nothing
    step(24'h02A800, 1, 16'hFFFF);
    step(24'h300000, 1, 16'hFFFF);
    step(24'h900000, 1, 16'hFFFF);
    step(24'h02A800, 0, 0);
    step(24'hA00000 + (5 << 11), 0, 0);

    // R8: a write cycle still shows the old entry
    step(24'hC00000 + (2 << 15), 1, 16'h0902);
    step(24'hC00000 + (2 << 15), 0, 0);
    step(24'h010000, 0, 0);

    // R2: switch to tag 1, reversed segment mapping
    step(24'hE00000, 1, 16'h1000);
    step(24'hE00000, 0, 0);
    for (int i = 0; i < 8; i++) step(24'hC00000 + (i << 15), 1, (7 - i) | 16'h0A00);
    for (int k = 0; k < 20; k++) step((k * 32'h2B1D7) % 32'h40000, 0, 0);
    // R7: page write through tag 1 segment map
    step(24'hA00000 + (3 << 11), 1, 16'hC123);
    step(24'h001800, 0, 0);

    // back to tag 0
    step(24'hE00000, 1, 16'h0FFF);
    for (int k = 0; k < 20; k++) step((k * 32'h2B1D7) % 32'h40000, 0, 0);
    step(24'h039800, 0, 0);

    // R2: tag 7 loads from data bits 15:12
    step(24'hE00000, 1, 16'h7000);
    step(24'hF12345, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule